// File: doc/BRIEF.md
# Glitchless Dual-Ratio Output Divider

This block produces a bank of divided clocks from one fast reference clock. Each output has two preset integer divide ratios. Two shared frequency-select pins pick between them: a low select uses the first ratio and a high select uses the second. A per-output mapping field decides which select pin, if either, steers each output. Only the lower outputs accept frequency selection; the upper outputs always run at their first ratio.

The select pins are asynchronous to the reference clock and pass through a two-flop synchronizer before use. A ratio change never cuts a period short. The output finishes the period it is in at the old ratio, and the first period at the new ratio starts with a rising edge. Every high and low phase is therefore a whole phase of one ratio or the other, and no runt pulse appears. A flag per output shows which ratio is running.

Top module: `dual_ratio_divider`

## Requirements
- R1: While rst_ni is low, every clk_o bit and every sel_active_o bit is 0. The first rising reference edge after reset starts a high phase on every output.
- R2: For an effective ratio N, the high phase lasts floor(N/2) reference cycles and the low phase lasts N - floor(N/2). A ratio word below 2 is treated as 2.
- R3: A select value of 0 picks ratio_a_i and a value of 1 picks ratio_b_i. sel_active_o is 0 while a period runs at ratio_a_i and 1 while it runs at ratio_b_i.
- R4: The 2-bit map field of output i sits at map_i[2i+1:2i]. Code 01 links the output to fsel_i[0], code 10 links it to fsel_i[1], and codes 00 and 11 link it to neither, which forces select 0.
- R5: Outputs with index NUM_SEL or above ignore both select pins and their map field, and always run at ratio_a_i (sel_active_o stays 0).
- R6: A level on fsel_i that is present at reference edge k is first used for a ratio decision at edge k+2.
- R7: The active ratio is reloaded only at the reference edge that ends a low phase. Every completed phase width equals a phase width of the old ratio or of the new ratio.
- R8: sel_active_o changes only on a cycle in which the matching clk_o rises.
- R9: Once a synchronized select level differs from sel_active_o, the two agree again within 2^RATIO_W reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ratio_a_i | input | NUM_OUT*RATIO_W | First ratio per output, output i at bits [i*RATIO_W +: RATIO_W] |
| ratio_b_i | input | NUM_OUT*RATIO_W | Second ratio per output, same packing |
| fsel_i | input | 2 | Shared asynchronous frequency-select pins |
| map_i | input | 2*NUM_OUT | Per-output select-pin link code |
| clk_o | output | NUM_OUT | Divided output clocks |
| sel_active_o | output | NUM_OUT | 1 while the period running uses the second ratio |

## Verification
With all map fields set to "none", toggling the pins must leave every output on its first ratio. This tells a working link decode apart from one that leaks a pin through. A mixed mapping that ties outputs to either pin, including the upper outputs that must ignore it, shows whether the routing and the pin-immune variant are correct. Select edges placed early and late in high and low phases, with holds of 1 to about 30 cycles, show whether a change waits for the end of the low phase and whether the two-edge synchronizer latency is exact. Ratio words of 0, 1, odd values and a long ratio exercise the clamp and the floor split of each period.

// File: rtl/drd_pkg.sv
package drd_pkg;
  typedef enum logic [1:0] {
    LINK_NONE = 2'b00,
    LINK_PIN0 = 2'b01,
    LINK_PIN1 = 2'b10,
    LINK_OFF  = 2'b11
  } link_e;
endpackage

// File: rtl/drd_sync.sv
module drd_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/drd_route.sv
module drd_route
  import drd_pkg::*;
#(
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned NUM_SEL = 6
) (
  input  logic [1:0]           pin_i,
  input  logic [2*NUM_OUT-1:0] map_i,
  output logic [NUM_OUT-1:0]   sel_o
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    if (i < NUM_SEL) begin : g_link
      link_e code;
      assign code = link_e'(map_i[2*i +: 2]);
      always_comb begin
        unique case (code)
          LINK_PIN0: sel_o[i] = pin_i[0];
          LINK_PIN1: sel_o[i] = pin_i[1];
          default:   sel_o[i] = 1'b0;
        endcase
      end
    end else begin : g_fixed
      assign sel_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/drd_divider.sv
module drd_divider #(
  parameter int unsigned RATIO_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_a_i,
  input  logic [RATIO_W-1:0] ratio_b_i,
  input  logic               sel_i,
  output logic               clk_o,
  output logic               sel_active_o
);
  localparam logic [RATIO_W-1:0] MinRatio = RATIO_W'(2);
  localparam logic [RATIO_W-1:0] One      = RATIO_W'(1);

  logic [RATIO_W-1:0] cnt_q, act_q, cnt_n, act_n, pend, eff;
  logic               started_q, clk_q, sel_q;
  logic               wrap;

  assign pend = sel_i ? ratio_b_i : ratio_a_i;
  assign eff  = (pend < MinRatio) ? MinRatio : pend;
  // period boundary: last low cycle, or first edge out of reset
  assign wrap = !started_q || (cnt_q == act_q - One);

  always_comb begin
    if (wrap) begin
      cnt_n = '0;
      act_n = eff;
    end else begin
      cnt_n = cnt_q + One;
      act_n = act_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      act_q     <= MinRatio;
      started_q <= 1'b0;
      clk_q     <= 1'b0;
      sel_q     <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      act_q     <= act_n;
      started_q <= 1'b1;
      clk_q     <= (cnt_n < (act_n >> 1));
      if (wrap) sel_q <= sel_i;
    end
  end

  assign clk_o        = clk_q;
  assign sel_active_o = sel_q;
endmodule

// File: rtl/dual_ratio_divider.sv
module dual_ratio_divider #(
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned NUM_SEL = 6,
  parameter int unsigned RATIO_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_OUT*RATIO_W-1:0] ratio_a_i,
  input  logic [NUM_OUT*RATIO_W-1:0] ratio_b_i,
  input  logic [1:0]                 fsel_i,
  input  logic [2*NUM_OUT-1:0]       map_i,
  output logic [NUM_OUT-1:0]         clk_o,
  output logic [NUM_OUT-1:0]         sel_active_o
);
  logic [1:0]         pin_sync;
  logic [NUM_OUT-1:0] route_sel;

  drd_sync #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (fsel_i),
    .q_o    (pin_sync)
  );

  drd_route #(.NUM_OUT(NUM_OUT), .NUM_SEL(NUM_SEL)) u_route (
    .pin_i (pin_sync),
    .map_i (map_i),
    .sel_o (route_sel)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_div
    drd_divider #(.RATIO_W(RATIO_W)) u_div (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ratio_a_i    (ratio_a_i[i*RATIO_W +: RATIO_W]),
      .ratio_b_i    (ratio_b_i[i*RATIO_W +: RATIO_W]),
      .sel_i        (route_sel[i]),
      .clk_o        (clk_o[i]),
      .sel_active_o (sel_active_o[i])
    );
  end
endmodule

// File: rtl/drd_check.sv
module drd_check #(
  parameter int unsigned NUM_OUT = 8,
  parameter int unsigned NUM_SEL = 6,
  parameter int unsigned RATIO_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_OUT-1:0] clk_o,
  input logic [NUM_OUT-1:0] sel_active_o,
  input logic [NUM_OUT-1:0] route_sel
);
  localparam int unsigned CW = RATIO_W + 2;
  localparam logic [CW-1:0] WinMax = CW'(2**RATIO_W);
  localparam logic [CW-1:0] HiMax  = CW'(2**(RATIO_W-1));

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
    logic [CW-1:0] wait_q, hi_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wait_q <= '0;
        hi_q   <= '0;
      end else begin
        if (route_sel[i] != sel_active_o[i]) begin
          if (wait_q != '1) wait_q <= wait_q + 1'b1;
        end else begin
          wait_q <= '0;
        end
        if (clk_o[i]) begin
          if (hi_q != '1) hi_q <= hi_q + 1'b1;
        end else begin
          hi_q <= '0;
        end
      end
    end

    assert_switch_on_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $changed(sel_active_o[i]) |-> $rose(clk_o[i]));

    assert_switch_bounded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wait_q <= WinMax);

    assert_high_phase_bounded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hi_q < HiMax);

    if (i >= NUM_SEL) begin : g_fixed
      assert_fixed_output_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_active_o[i]);
    end
  end
endmodule

bind dual_ratio_divider drd_check #(
  .NUM_OUT (NUM_OUT),
  .NUM_SEL (NUM_SEL),
  .RATIO_W (RATIO_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clk_o        (clk_o),
  .sel_active_o (sel_active_o),
  .route_sel    (route_sel)
);

// File: tb/dual_ratio_divider_tb_top.sv
`timescale 1ns/1ps
module dual_ratio_divider_tb_top;
  localparam int NO = 8;
  localparam int NS = 6;
  localparam int RW = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NO*RW-1:0]  ra, rb;
  logic [1:0]        fsel;
  logic [2*NO-1:0]   map;
  logic [NO-1:0]     clk_o, sel_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  dual_ratio_divider #(.NUM_OUT(NO), .NUM_SEL(NS), .RATIO_W(RW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ratio_a_i(ra), .ratio_b_i(rb),
    .fsel_i(fsel), .map_i(map), .clk_o(clk_o), .sel_active_o(sel_o)
  );

  // behavioural reference model
  int m_started[NO], m_cnt[NO], m_act[NO], m_sel[NO], m_clk[NO];
  int run_len[NO], last_v[NO], seen_rise[NO];
  logic [1:0] pin_hist[$];
  int edges;

  function automatic int eff_ratio(int r);
    return (r < 2) ? 2 : r;
  endfunction

  function automatic int rat(int i, int b);
    return b ? int'(rb[i*RW +: RW]) : int'(ra[i*RW +: RW]);
  endfunction

  function automatic int want_sel(int i, logic [1:0] p);
    if (i >= NS) return 0;
    case (map[2*i +: 2])
      2'b01:   return int'(p[0]);
      2'b10:   return int'(p[1]);
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [NO*RW-1:0] a, input logic [NO*RW-1:0] b,
                          input logic [2*NO-1:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    ra = a; rb = b; map = m; fsel = 2'b00;
    repeat (3) @(negedge clk);
    check(clk_o == '0, "R1 clk_o in reset", int'(clk_o), 0);
    check(sel_o == '0, "R1 sel_active_o in reset", int'(sel_o), 0);
    for (int i = 0; i < NO; i++) begin
      m_started[i] = 0; m_cnt[i] = 0; m_act[i] = 2; m_sel[i] = 0; m_clk[i] = 0;
      run_len[i] = 0; last_v[i] = 0; seen_rise[i] = 0;
    end
    pin_hist.delete();
    edges = 0;
    rst_n = 1'b1;
  endtask

  // one reference edge has passed; update model and compare
  task automatic step();
    logic [1:0] used;
    @(negedge clk);
    edges++;
    pin_hist.push_back(fsel);
    used = (edges >= 3) ? pin_hist[edges-3] : 2'b00;
    for (int i = 0; i < NO; i++) begin
      int s;
      s = want_sel(i, used);
      if (!m_started[i] || m_cnt[i] == m_act[i] - 1) begin
        m_started[i] = 1; m_cnt[i] = 0;
        m_act[i] = eff_ratio(rat(i, s));
        m_sel[i] = s;
      end else begin
        m_cnt[i]++;
      end
      m_clk[i] = (m_cnt[i] < m_act[i] / 2) ? 1 : 0;
      if (edges == 1)
        check(clk_o[i] == 1'b1, "R1 first edge starts high", int'(clk_o[i]), 1);
      check(int'(clk_o[i]) == m_clk[i], "R2 R7 clk_o waveform", int'(clk_o[i]), m_clk[i]);
      check(int'(sel_o[i]) == m_sel[i], "R3 R4 R6 sel_active_o", int'(sel_o[i]), m_sel[i]);
      if (i >= NS) check(sel_o[i] == 1'b0, "R5 fixed output flag", int'(sel_o[i]), 0);
      // phase width check
      if (int'(clk_o[i]) != last_v[i]) begin
        if (seen_rise[i]) begin
          int na, nb, w;
          bit ok;
          na = eff_ratio(rat(i, 0)); nb = eff_ratio(rat(i, 1)); w = run_len[i];
          if (last_v[i] == 1) ok = (w == na/2) || (w == nb/2);
          else ok = (w == na - na/2) || (w == nb - nb/2);
          check(ok, "R7 R2 phase width", w, last_v[i] ? na/2 : na - na/2);
        end
        if (clk_o[i]) seen_rise[i] = 1;
        last_v[i] = int'(clk_o[i]);
        run_len[i] = 1;
      end else begin
        run_len[i]++;
      end
    end
  endtask

  task automatic hold(input logic [1:0] p, input int cyc);
    fsel = p;
    for (int c = 0; c < cyc; c++) step();
  endtask

  // after a long stable hold, flags must match the mapped pins
  task automatic settle_check(input logic [1:0] p);
    hold(p, 2**RW + 4);
    for (int i = 0; i < NO; i++)
      check(int'(sel_o[i]) == want_sel(i, p), "R9 settled select", int'(sel_o[i]), want_sel(i, p));
  endtask

  initial begin
    logic [NO*RW-1:0] a, b;
    ra = '0; rb = '0; map = '0; fsel = '0;
    // segment 1: nothing linked, pins toggle, outputs stay on ratio A (R4)
    a = {8'd9, 8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2};
    b = {8'd6, 8'd6, 8'd10, 8'd3, 8'd2, 8'd7, 8'd4, 8'd5};
    do_reset(a, b, {2'b00, 2'b11, 2'b00, 2'b11, 2'b00, 2'b11, 2'b00, 2'b00});
    hold(2'b11, 40); hold(2'b01, 17); hold(2'b10, 23);
    settle_check(2'b11);
    // segment 2: mixed links, upper outputs linked but must ignore (R5)
    do_reset(a, b, {2'b10, 2'b01, 2'b01, 2'b11, 2'b10, 2'b01, 2'b10, 2'b01});
    hold(2'b00, 5); hold(2'b01, 1); hold(2'b00, 9); hold(2'b11, 3);
    hold(2'b10, 20); hold(2'b01, 2); hold(2'b11, 13); hold(2'b00, 7);
    settle_check(2'b11);
    settle_check(2'b01);
    // segment 3: clamp of 0 and 1, odd ratios, pseudo-random pin activity
    a = {8'd1, 8'd0, 8'd11, 8'd1, 8'd0, 8'd3, 8'd1, 8'd0};
    b = {8'd5, 8'd5, 8'd1, 8'd13, 8'd9, 8'd0, 8'd7, 8'd4};
    do_reset(a, b, {2'b01, 2'b10, 2'b01, 2'b10, 2'b01, 2'b10, 2'b01, 2'b10});
    for (int k = 0; k < 60; k++) hold(2'($urandom_range(0, 3)), $urandom_range(1, 30));
    settle_check(2'b10);
    // segment 4: long ratio on one output
    a = {8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd200};
    b = {8'd5, 8'd5, 8'd5, 8'd5, 8'd5, 8'd5, 8'd5, 8'd31};
    do_reset(a, b, {2'b00, 2'b00, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01});
    hold(2'b00, 50); hold(2'b01, 300); hold(2'b00, 90);
    settle_check(2'b01);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule